// File: doc/BRIEF.md
# BCD to Seven-Segment Decoder with Zero Suppression

This block turns one 4-bit BCD digit into seven active-low segment drives for a common-anode display. On top of the plain lookup it has three overrides: a forced blank request, a lamp test that lights every segment, and a ripple-blank input. When the ripple-blank input is asserted and the digit is zero, the digit goes dark and a ripple-blank output tells the next, less significant digit that it may blank a zero as well.

The blanking request and the ripple-blank output stand on two separate ports. The classic single pin is a wired-AND node that both drives and receives. To rebuild that node, a user ANDs each digit's ripple-blank output with any external blank source and feeds the result back to that digit's blank request. The ripple-blank output does not depend on the blank request, so this loop settles without oscillation. The block is purely combinational.

Segment bits are ordered `segN[0]`=a, `[1]`=b, `[2]`=c, `[3]`=d, `[4]`=e, `[5]`=f, `[6]`=g. A 0 lights a segment. The patterns below are given as `segN` in hex.

Top module: `bcd_seg_decoder`

## Requirements
- R1: With `blankReqN`, `lampTestN` and `rippleInN` all high, the digits 0 to 9 drive `segN` = 40, 79, 24, 30, 19, 12, 02, 78, 00, 10 (hex) in that order.
- R2: Digit 6 lights segment a (`segN[0]`=0) and digit 9 lights segment d (`segN[3]`=0). These are the tailed shapes.
- R3: Codes 10 to 15 drive `segN` = 27, 33, 1D, 16, 07, 7F. They are never taken as a blank request: `rippleOutN` stays high for them.
- R4: With `blankReqN` high and `lampTestN` low, `segN` = 00 for every digit and every `rippleInN`.
- R5: With `blankReqN` and `lampTestN` high, `rippleInN` low and digit 0, `segN` = 7F and `rippleOutN` is low.
- R6: `rippleOutN` is high whenever the digit is nonzero, `rippleInN` is high, or `lampTestN` is low.
- R7: With `blankReqN` low, `segN` = 7F whatever `lampTestN`, `rippleInN` and `digit` are.
- R8: `blankReqN` has no effect on `rippleOutN`.
- R9: In a chain built with the wired-AND model, where each digit's `rippleInN` comes from the `rippleOutN` of the more significant digit, the leading zeros go dark. A zero after the first nonzero digit stays lit, and so does the least significant digit when its `rippleInN` is tied high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit | input | 4 | BCD code to display |
| lampTestN | input | 1 | Active-low: light all segments |
| rippleInN | input | 1 | Active-low: blank this digit if it is zero |
| blankReqN | input | 1 | Active-low: force all segments off |
| segN | output | 7 | Active-low segment drives, bit 0 = a through bit 6 = g |
| rippleOutN | output | 1 | Active-low: this digit was zero-suppressed |

## Verification
The block holds no state, so any fault shows up as a wrong value on `segN` or `rippleOutN` in the same cycle the inputs change. A wrong override priority shows as lit segments under a blank request, or as a dark display during lamp test. A flawed zero detector shows up in the chain as a trailing zero that vanishes or a leading zero that stays lit. A wrong table entry shows up at exactly one code, so all sixteen codes are applied.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef struct packed {
    logic blankAll;   // force every segment dark
    logic lightAll;   // force every segment lit
    logic zeroBlank;  // suppress a zero digit
  } segStrobes_t;

  // Active-high shape; bit 0 = a ... bit 6 = g
  function automatic logic [SEG_W-1:0] shapeOf(input logic [DIGIT_W-1:0] code);
    logic [SEG_W-1:0] s;
    case (code)
      4'd0:  s = 7'h3F;
      4'd1:  s = 7'h06;
      4'd2:  s = 7'h5B;
      4'd3:  s = 7'h4F;
      4'd4:  s = 7'h66;
      4'd5:  s = 7'h6D;
      4'd6:  s = 7'h7D;  // tailed six
      4'd7:  s = 7'h07;
      4'd8:  s = 7'h7F;
      4'd9:  s = 7'h6F;  // tailed nine
      4'd10: s = 7'h58;
      4'd11: s = 7'h4C;
      4'd12: s = 7'h62;
      4'd13: s = 7'h69;
      4'd14: s = 7'h78;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bcd_seg_ctrl.sv
module bcd_seg_ctrl
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  logic               lampTestN,
  input  logic               rippleInN,
  input  logic               blankReqN,
  output segStrobes_t        strobes,
  output logic               rippleOutN
);
  logic isZero;
  logic suppress;

  always_comb begin
    isZero   = (digit == '0);
    suppress = isZero && !rippleInN && lampTestN;
    strobes.blankAll  = !blankReqN;
    strobes.lightAll  = blankReqN && !lampTestN;
    strobes.zeroBlank = blankReqN && suppress;
    rippleOutN = !suppress;
  end
endmodule

// File: rtl/bcd_seg_datapath.sv
module bcd_seg_datapath
  import bcd_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit,
  input  segStrobes_t        strobes,
  output logic [SEG_W-1:0]   segN
);
  logic [SEG_W-1:0] shape;

  always_comb shape = shapeOf(digit);

  for (genvar i = 0; i < SEG_W; i++) begin : g_seg
    always_comb begin
      if (strobes.blankAll || strobes.zeroBlank) segN[i] = 1'b1;
      else if (strobes.lightAll)                 segN[i] = 1'b0;
      else                                       segN[i] = !shape[i];
    end
  end
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
(
  input  logic [3:0] digit,
  input  logic       lampTestN,
  input  logic       rippleInN,
  input  logic       blankReqN,
  output logic [6:0] segN,
  output logic       rippleOutN
);
  segStrobes_t strobes;

  bcd_seg_ctrl ctrl_i (
    .digit(digit), .lampTestN(lampTestN), .rippleInN(rippleInN),
    .blankReqN(blankReqN), .strobes(strobes), .rippleOutN(rippleOutN)
  );

  bcd_seg_datapath dp_i (
    .digit(digit), .strobes(strobes), .segN(segN)
  );
endmodule

// File: rtl/bcd_seg_decoder_checker.sv
module bcd_seg_decoder_checker (
  input logic [3:0] digit,
  input logic       lampTestN,
  input logic       rippleInN,
  input logic       blankReqN,
  input logic [6:0] segN,
  input logic       rippleOutN
);
  always_comb begin
    if (!blankReqN)
      assert_blank_dominates_R7: assert (segN == 7'h7F)
        else $error("R7 blank request left segments lit");
    if (blankReqN && !lampTestN)
      assert_lamp_test_R4: assert (segN == 7'h00)
        else $error("R4 lamp test did not light all");
    if (blankReqN && lampTestN && !rippleInN && digit == 4'd0)
      assert_zero_suppress_R5: assert (segN == 7'h7F && !rippleOutN)
        else $error("R5 zero not suppressed");
    if (digit != 4'd0 || rippleInN || !lampTestN)
      assert_ripple_high_R6: assert (rippleOutN)
        else $error("R6 ripple output low unexpectedly");
    if (blankReqN && lampTestN && digit > 4'd9 && digit != 4'd15)
      assert_high_codes_lit_R3: assert (segN != 7'h7F)
        else $error("R3 high code blanked");
  end
endmodule

bind bcd_seg_decoder bcd_seg_decoder_checker chk_i (
  .digit(digit), .lampTestN(lampTestN), .rippleInN(rippleInN),
  .blankReqN(blankReqN), .segN(segN), .rippleOutN(rippleOutN)
);

// File: tb/bcd_seg_decoder_tb_top.sv
module bcd_seg_decoder_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [3:0] digit = 4'd0;
  logic lampTestN = 1'b1, rippleInN = 1'b1, blankReqN = 1'b1;
  logic [6:0] segN;
  logic rippleOutN;

  bcd_seg_decoder dut_i (
    .digit(digit), .lampTestN(lampTestN), .rippleInN(rippleInN),
    .blankReqN(blankReqN), .segN(segN), .rippleOutN(rippleOutN)
  );

  // four-digit chain, d3 most significant, wired-AND blank node per digit
  logic [3:0] c3, c2, c1, c0;
  logic extBlankN = 1'b1;
  logic [6:0] s3, s2, s1, s0;
  logic r3o, r2o, r1o, r0o;
  logic b3, b2, b1, b0;
  assign b3 = r3o & extBlankN;
  assign b2 = r2o & extBlankN;
  assign b1 = r1o & extBlankN;
  assign b0 = r0o & extBlankN;

  bcd_seg_decoder dig3_i (.digit(c3), .lampTestN(1'b1), .rippleInN(1'b0), .blankReqN(b3), .segN(s3), .rippleOutN(r3o));
  bcd_seg_decoder dig2_i (.digit(c2), .lampTestN(1'b1), .rippleInN(r3o),  .blankReqN(b2), .segN(s2), .rippleOutN(r2o));
  bcd_seg_decoder dig1_i (.digit(c1), .lampTestN(1'b1), .rippleInN(r2o),  .blankReqN(b1), .segN(s1), .rippleOutN(r1o));
  bcd_seg_decoder dig0_i (.digit(c0), .lampTestN(1'b1), .rippleInN(1'b1), .blankReqN(b0), .segN(s0), .rippleOutN(r0o));

  // {blankReqN, lampTestN, rippleInN, digit, expSegN, expRippleOutN}
  localparam int NVEC = 26;
  localparam logic [14:0] VECS [NVEC] = '{
    {3'b111, 4'd0,  7'h40, 1'b1}, {3'b111, 4'd1,  7'h79, 1'b1},
    {3'b111, 4'd2,  7'h24, 1'b1}, {3'b111, 4'd3,  7'h30, 1'b1},
    {3'b111, 4'd4,  7'h19, 1'b1}, {3'b111, 4'd5,  7'h12, 1'b1},
    {3'b111, 4'd6,  7'h02, 1'b1}, {3'b111, 4'd7,  7'h78, 1'b1},
    {3'b111, 4'd8,  7'h00, 1'b1}, {3'b111, 4'd9,  7'h10, 1'b1},
    {3'b111, 4'd10, 7'h27, 1'b1}, {3'b111, 4'd11, 7'h33, 1'b1},
    {3'b111, 4'd12, 7'h1D, 1'b1}, {3'b111, 4'd13, 7'h16, 1'b1},
    {3'b111, 4'd14, 7'h07, 1'b1}, {3'b111, 4'd15, 7'h7F, 1'b1},
    {3'b101, 4'd5,  7'h00, 1'b1}, {3'b100, 4'd0,  7'h00, 1'b1},
    {3'b101, 4'd15, 7'h00, 1'b1}, {3'b110, 4'd0,  7'h7F, 1'b0},
    {3'b110, 4'd3,  7'h30, 1'b1}, {3'b110, 4'd10, 7'h27, 1'b1},
    {3'b001, 4'd8,  7'h7F, 1'b1}, {3'b010, 4'd0,  7'h7F, 1'b0},
    {3'b000, 4'd0,  7'h7F, 1'b1}, {3'b010, 4'd6,  7'h7F, 1'b1}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    c3 = 0; c2 = 0; c1 = 0; c0 = 0;
    @(negedge clk);
    // idle state: all overrides inactive, digit 0 shows "0" (R1)
    check("R1", {1'b0, segN}, {1'b0, 7'h40});
    check("R6", {7'b0, rippleOutN}, 8'd1);

    for (int i = 0; i < NVEC; i++) begin
      string segTag, ripTag;
      @(posedge clk);
      {blankReqN, lampTestN, rippleInN, digit} = VECS[i][14:8];
      @(negedge clk);
      if (!blankReqN) segTag = "R7";
      else if (!lampTestN) segTag = "R4";
      else if (!rippleInN && digit == 4'd0) segTag = "R5";
      else if (digit > 4'd9) segTag = "R3";
      else if (digit == 4'd6 || digit == 4'd9) segTag = "R2";
      else segTag = "R1";
      if (!blankReqN) ripTag = "R8";
      else if (!VECS[i][0]) ripTag = "R5";
      else ripTag = "R6";
      check(segTag, {1'b0, segN}, {1'b0, VECS[i][7:1]});
      check(ripTag, {7'b0, rippleOutN}, {7'b0, VECS[i][0]});
    end

    // R2: tail segments of six and nine
    @(posedge clk); {blankReqN, lampTestN, rippleInN} = 3'b111; digit = 4'd6;
    @(negedge clk); check("R2", {7'b0, segN[0]}, 8'd0);
    @(posedge clk); digit = 4'd9;
    @(negedge clk); check("R2", {7'b0, segN[3]}, 8'd0);

    // R8: rippleOutN same with blank request toggled, zero digit, ripple in low
    @(posedge clk); {blankReqN, lampTestN, rippleInN} = 3'b110; digit = 4'd0;
    @(negedge clk); check("R8", {7'b0, rippleOutN}, 8'd0);
    @(posedge clk); blankReqN = 1'b0;
    @(negedge clk); check("R8", {7'b0, rippleOutN}, 8'd0);

    // R9: chained leading-zero suppression
    @(posedge clk); {c3, c2, c1, c0} = {4'd0, 4'd0, 4'd4, 4'd0};
    @(negedge clk);
    check("R9", {1'b0, s3}, 8'h7F); check("R9", {1'b0, s2}, 8'h7F);
    check("R9", {1'b0, s1}, 8'h19); check("R9", {1'b0, s0}, 8'h40);
    @(posedge clk); {c3, c2, c1, c0} = {4'd0, 4'd0, 4'd0, 4'd0};
    @(negedge clk);
    check("R9", {1'b0, s3}, 8'h7F); check("R9", {1'b0, s2}, 8'h7F);
    check("R9", {1'b0, s1}, 8'h7F); check("R9", {1'b0, s0}, 8'h40);
    @(posedge clk); {c3, c2, c1, c0} = {4'd0, 4'd7, 4'd0, 4'd0};
    @(negedge clk);
    check("R9", {1'b0, s3}, 8'h7F); check("R9", {1'b0, s2}, 8'h78);
    check("R9", {1'b0, s1}, 8'h40); check("R9", {1'b0, s0}, 8'h40);
    @(posedge clk); extBlankN = 1'b0;
    @(negedge clk);
    check("R7", {1'b0, s2}, 8'h7F); check("R7", {1'b0, s0}, 8'h7F);

    finish_run();
  end
endmodule